// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block holds the control and status word that sits beside a floating-point datapath. The word carries a rounding-mode field, a denormal-flush bit and three five-bit exception fields: the flags of the latest reporting operation, a sticky cause accumulator, and a trap-enable mask. The datapath reports each finished operation with its operation kind, five raw exception indications and, for compares, the ordering relation of the operands. The block rewrites the flags, merges them into the cause field, and raises a one-cycle trap request with a fixed code when an enabled cause is present.

The block also evaluates the condition bit for the two compare kinds, equality and greater-than. An ordered compare only sets or clears that bit. An unordered compare leaves the bit alone and instead updates the status fields. A masked write port loads the whole word, and the block decodes the rounding and flush controls back to the datapath.

Top module: `fpsr_unit`

## Requirements
- R1: After synchronous reset, `csr_q` is 0, and `tbit`, `trap_req`, `trap_code`, `round_trunc` and `flush_denorm` are all 0.
- R2: A write (`wr_en`=1) stores `wr_data & 32'h0005_FFFF` on the next clock. Bits 31:19 and bit 17 always read 0. The layout is: rounding mode 1:0, flags 6:2, enable 11:7, cause 16:12, flush bit 18.
- R3: A reporting operation replaces the flag field 6:2 with `exc_in`, and an all-zero `exc_in` clears it. Inside every five-bit field, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. `op_kind` 0 is an arithmetic operation and always reports.
- R4: A reporting operation ORs `exc_in` into the cause field 16:12. Cause bits are only cleared by a write.
- R5: In the cycle after a reporting operation whose `exc_in` is nonzero and whose updated cause overlaps the enable field, `trap_req` is high for one cycle. During that cycle `trap_code` is 12'h120 and `csr_q` already shows the updated fields. At all other times `trap_code` is 0.
- R6: `round_trunc` is 1 exactly when the rounding field equals 2'b01 (toward zero). Every other value selects round-to-nearest-even (`round_trunc`=0).
- R7: `flush_denorm` follows bit 18 of the word.
- R8: For `op_kind` 1 (equal) or 2 (greater), with `rel` 0=less, 1=equal, 2=greater, an ordered relation sets `tbit` when it matches the kind and clears it otherwise. `csr_q` stays unchanged.
- R9: A compare with `rel`=3 (unordered) leaves `tbit` unchanged and updates the fields and trap as in R3 to R5.
- R10: When a write and an operation fall in the same cycle, the written value wins, no trap is raised, and the compare's effect on `tbit` still applies.
- R11: `op_kind` 3 and cycles with `op_valid`=0 change neither the word nor `tbit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation finished this cycle |
| op_kind | input | 2 | 0 arithmetic, 1 compare-equal, 2 compare-greater, 3 none |
| rel | input | 2 | Compare relation: 0 less, 1 equal, 2 greater, 3 unordered |
| exc_in | input | 5 | Raw exception indications from the datapath |
| wr_en | input | 1 | Load the word |
| wr_data | input | 32 | Value to load (masked) |
| csr_q | output | 32 | Current control/status word |
| tbit | output | 1 | Compare condition bit |
| round_trunc | output | 1 | Datapath rounds toward zero |
| flush_denorm | output | 1 | Datapath flushes denormals |
| trap_req | output | 1 | One-cycle exception request |
| trap_code | output | 12 | Exception code while `trap_req` is high |

## Verification
A register write and a reporting operation can fall in the same clock cycle, and the write must take priority over the status update and the trap. The bench provokes this by driving a write together with an arithmetic operation whose exception is enabled, and then a write together with an ordered compare. It judges the outcome by checking that the word equals the masked write data, that `trap_req` stays low, and that `tbit` still takes the compare result.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;

    parameter int REG_W     = 32;
    parameter int FLD_W     = 5;
    parameter int RM_W      = 2;
    parameter int RM_LSB    = 0;
    parameter int FLAG_LSB  = 2;
    parameter int EN_LSB    = 7;
    parameter int CAUSE_LSB = 12;
    parameter int FLUSH_BIT = 18;
    parameter int CODE_W    = 12;

    localparam logic [CODE_W-1:0] TRAP_CODE = CODE_W'(12'h120);
    localparam logic [RM_W-1:0]   RM_TRUNC  = 2'b01;
    localparam logic [REG_W-1:0]  WR_MASK   =
        ((REG_W'(1) << (CAUSE_LSB + FLD_W)) - REG_W'(1)) | (REG_W'(1) << FLUSH_BIT);

    typedef enum logic [1:0] {
        OP_ARITH  = 2'd0,
        OP_CMP_EQ = 2'd1,
        OP_CMP_GT = 2'd2,
        OP_NONE   = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        REL_LT    = 2'd0,
        REL_EQ    = 2'd1,
        REL_GT    = 2'd2,
        REL_UNORD = 2'd3
    } rel_e;

    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_t;

    typedef struct packed {
        logic [RM_W-1:0]  rm;
        logic             flush;
        logic [FLD_W-1:0] flag;
        logic [FLD_W-1:0] enable;
        logic [FLD_W-1:0] cause;
    } fields_t;

    function automatic fields_t unpack_word(input logic [REG_W-1:0] w);
        fields_t f;
        f.rm     = w[RM_LSB +: RM_W];
        f.flush  = w[FLUSH_BIT];
        f.flag   = w[FLAG_LSB +: FLD_W];
        f.enable = w[EN_LSB +: FLD_W];
        f.cause  = w[CAUSE_LSB +: FLD_W];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input fields_t f);
        logic [REG_W-1:0] w;
        w = '0;
        w[RM_LSB +: RM_W]       = f.rm;
        w[FLUSH_BIT]            = f.flush;
        w[FLAG_LSB +: FLD_W]    = f.flag;
        w[EN_LSB +: FLD_W]      = f.enable;
        w[CAUSE_LSB +: FLD_W]   = f.cause;
        return w;
    endfunction

endpackage

// File: rtl/fpsr_cmp.sv
module fpsr_cmp
    import fpsr_pkg::*;
(
    input  logic     op_valid,
    input  op_kind_e kind,
    input  rel_e     rel,
    input  logic     t_q,
    output logic     t_next,
    output logic     report
);
    always_comb begin
        t_next = t_q;
        report = 1'b0;
        if (op_valid) begin
            unique case (kind)
                OP_ARITH: report = 1'b1;
                OP_CMP_EQ: begin
                    if (rel == REL_UNORD) report = 1'b1;
                    else                  t_next = (rel == REL_EQ);
                end
                OP_CMP_GT: begin
                    if (rel == REL_UNORD) report = 1'b1;
                    else                  t_next = (rel == REL_GT);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fpsr_update.sv
module fpsr_update
    import fpsr_pkg::*;
(
    input  fields_t cur,
    input  logic    report,
    input  exc_t    exc,
    output fields_t nxt,
    output logic    trap
);
    logic [FLD_W-1:0] exc_vec;
    logic [FLD_W-1:0] merged;

    assign exc_vec = exc;

    for (genvar i = 0; i < FLD_W; i++) begin : g_merge
        assign merged[i] = cur.cause[i] | exc_vec[i];
    end

    always_comb begin
        nxt  = cur;
        trap = 1'b0;
        if (report) begin
            nxt.flag  = exc_vec;
            nxt.cause = merged;
            trap      = (|exc_vec) && (|(merged & cur.enable));
        end
    end
endmodule

// File: rtl/fpsr_ctrl_out.sv
module fpsr_ctrl_out
    import fpsr_pkg::*;
(
    input  fields_t cur,
    output logic    round_trunc,
    output logic    flush_denorm
);
    assign round_trunc  = (cur.rm == RM_TRUNC);
    assign flush_denorm = cur.flush;
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [1:0]        rel,
    input  logic [FLD_W-1:0]  exc_in,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  csr_q,
    output logic              tbit,
    output logic              round_trunc,
    output logic              flush_denorm,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    logic [REG_W-1:0] csr_r, csr_d;
    logic             t_r, t_d;
    logic             trap_r, trap_d;
    logic             report;
    logic             trap_hit;
    fields_t          cur_f, upd_f;

    assign cur_f = unpack_word(csr_r);

    fpsr_cmp u_cmp (
        .op_valid (op_valid),
        .kind     (op_kind_e'(op_kind)),
        .rel      (rel_e'(rel)),
        .t_q      (t_r),
        .t_next   (t_d),
        .report   (report)
    );

    fpsr_update u_upd (
        .cur    (cur_f),
        .report (report),
        .exc    (exc_t'(exc_in)),
        .nxt    (upd_f),
        .trap   (trap_hit)
    );

    fpsr_ctrl_out u_ctl (
        .cur          (cur_f),
        .round_trunc  (round_trunc),
        .flush_denorm (flush_denorm)
    );

    always_comb begin
        if (wr_en) begin
            csr_d  = wr_data & WR_MASK;
            trap_d = 1'b0;
        end else begin
            csr_d  = pack_word(upd_f);
            trap_d = trap_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_r  <= '0;
            t_r    <= 1'b0;
            trap_r <= 1'b0;
        end else begin
            csr_r  <= csr_d;
            t_r    <= t_d;
            trap_r <= trap_d;
        end
    end

    assign csr_q     = csr_r;
    assign tbit      = t_r;
    assign trap_req  = trap_r;
    assign trap_code = trap_r ? TRAP_CODE : '0;
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker
    import fpsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [1:0]        op_kind,
    input logic [1:0]        rel,
    input logic              wr_en,
    input logic [REG_W-1:0]  csr_q,
    input logic              round_trunc,
    input logic              flush_denorm,
    input logic              trap_req,
    input logic [CODE_W-1:0] trap_code
);
    logic [FLD_W-1:0] cause_v, en_v;
    assign cause_v = csr_q[CAUSE_LSB +: FLD_W];
    assign en_v    = csr_q[EN_LSB +: FLD_W];

    assert_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (csr_q & ~WR_MASK) == '0);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (($past(cause_v) & ~cause_v) == '0));

    assert_trap_code_R5: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (trap_code == TRAP_CODE) && ((cause_v & en_v) != '0));

    assert_idle_code_R5: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> trap_code == '0);

    assert_round_R6: assert property (@(posedge clk) disable iff (rst)
        round_trunc == (csr_q[RM_LSB +: RM_W] == RM_TRUNC));

    assert_flush_R7: assert property (@(posedge clk) disable iff (rst)
        flush_denorm == csr_q[FLUSH_BIT]);

    assert_ordered_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !wr_en && (op_kind == 2'd1 || op_kind == 2'd2) && rel != 2'd3)
        |=> $stable(csr_q));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(op_valid) && !$past(wr_en));

    assert_none_R11: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && (!op_valid || op_kind == 2'd3)) |=> $stable(csr_q) && !trap_req);
endmodule

bind fpsr_unit fpsr_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .rel          (rel),
    .wr_en        (wr_en),
    .csr_q        (csr_q),
    .round_trunc  (round_trunc),
    .flush_denorm (flush_denorm),
    .trap_req     (trap_req),
    .trap_code    (trap_code)
);

// File: tb/sim_fpsr_unit.sv
`timescale 1ns/1ps
module sim_fpsr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [1:0]  rel = 2'd0;
    logic [4:0]  exc_in = 5'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] csr_q;
    logic        tbit, round_trunc, flush_denorm, trap_req;
    logic [11:0] trap_code;

    always #10 clk = ~clk;

    fpsr_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .rel(rel),
        .exc_in(exc_in), .wr_en(wr_en), .wr_data(wr_data), .csr_q(csr_q),
        .tbit(tbit), .round_trunc(round_trunc), .flush_denorm(flush_denorm),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    typedef struct {
        logic [31:0] csr;
        logic        t;
        logic        trap;
        logic [11:0] code;
        logic        rtr;
        logic        fl;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;

    logic [31:0] m_csr = 32'd0;
    logic        m_t = 1'b0;

    task automatic compare(input exp_t e);
        n_checks++;
        if (csr_q !== e.csr || tbit !== e.t || trap_req !== e.trap ||
            trap_code !== e.code || round_trunc !== e.rtr || flush_denorm !== e.fl) begin
            n_fail++;
            $display("FAIL %s: got csr=%h t=%b trap=%b code=%h rtr=%b fl=%b, expected csr=%h t=%b trap=%b code=%h rtr=%b fl=%b",
                e.tag, csr_q, tbit, trap_req, trap_code, round_trunc, flush_denorm,
                e.csr, e.t, e.trap, e.code, e.rtr, e.fl);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] k, input logic [4:0] x,
                         input logic [1:0] r, input logic we, input logic [31:0] wd,
                         input string tag);
        exp_t e;
        logic rep;
        logic trp;
        logic [4:0] c;
        @(negedge clk);
        op_valid = v; op_kind = k; exc_in = x; rel = r; wr_en = we; wr_data = wd;
        rep = v && (k == 2'd0 || ((k == 2'd1 || k == 2'd2) && r == 2'd3));
        trp = 1'b0;
        if (v && k == 2'd1 && r != 2'd3) m_t = (r == 2'd1);
        if (v && k == 2'd2 && r != 2'd3) m_t = (r == 2'd2);
        if (we) begin
            m_csr = wd & 32'h0005_FFFF;
        end else if (rep) begin
            m_csr[6:2] = x;
            c = m_csr[16:12] | x;
            m_csr[16:12] = c;
            trp = (x != 5'd0) && ((c & m_csr[11:7]) != 5'd0);
        end
        e.csr = m_csr; e.t = m_t; e.trap = trp;
        e.code = trp ? 12'h120 : 12'h000;
        e.rtr = (m_csr[1:0] == 2'b01); e.fl = m_csr[18]; e.tag = tag;
        @(posedge clk);
        q.push_back(e);
        #1;
        op_valid = 1'b0; wr_en = 1'b0;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

    initial begin : stim
        exp_t e0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        e0.csr = 32'd0; e0.t = 0; e0.trap = 0; e0.code = 12'h0; e0.rtr = 0; e0.fl = 0;
        e0.tag = "R1 reset";
        compare(e0);

        drive(0, 0, 0, 0, 1, 32'hFFFF_FFFF, "R2 masked write, R6 rm=11, R7 flush");
        drive(0, 0, 0, 0, 1, 32'h0000_0000, "R2 clear");
        drive(1, 0, 5'b00001, 0, 0, 0, "R3 R4 inexact flag");
        drive(1, 0, 5'b00000, 0, 0, 0, "R3 flags cleared, R4 cause kept");
        drive(1, 0, 5'b10000, 0, 0, 0, "R3 invalid, R4 accumulate");
        drive(0, 0, 0, 0, 1, 32'h0004_0201, "R6 toward-zero, R7 flush, enable overflow");
        drive(1, 0, 5'b00100, 0, 0, 0, "R5 enabled overflow trap");
        drive(0, 0, 0, 0, 0, 0, "R5 trap single cycle");
        drive(1, 0, 5'b00001, 0, 0, 0, "R5 sticky cause traps again");
        drive(1, 0, 5'b00000, 0, 0, 0, "R5 no trap without exception");
        drive(1, 1, 5'b11111, 1, 0, 0, "R8 eq/equal sets T");
        drive(1, 2, 5'b11111, 1, 0, 0, "R8 gt/equal clears T");
        drive(1, 2, 0, 2, 0, 0, "R8 gt/greater sets T");
        drive(1, 1, 0, 0, 0, 0, "R8 eq/less clears T");
        drive(1, 2, 0, 2, 0, 0, "R8 gt/greater sets T again");
        drive(1, 2, 5'b10000, 3, 0, 0, "R9 unordered keeps T, reports, traps");
        drive(1, 1, 5'b00010, 3, 0, 0, "R9 unordered eq reports underflow");
        drive(1, 3, 5'b01000, 0, 0, 0, "R11 kind 3 no effect");
        drive(0, 0, 5'b01000, 0, 0, 0, "R11 invalid op no effect");
        drive(1, 0, 5'b00100, 0, 1, 32'h0000_0200, "R10 write beats arith, no trap");
        drive(1, 1, 0, 0, 1, 32'h0000_0002, "R10 write with compare, T still updates");
        drive(0, 0, 0, 0, 1, 32'h0000_0003, "R6 rm=11 nearest");
        drive(0, 0, 0, 0, 0, 0, "R11 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule